// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Element

This block is one programmable logic cell. Its core is a truth table of `2**K` bits (64 for the default six inputs) that a binary tree of 2:1 multiplexers reads out. The input vector is used as an address. The first level of the tree is steered by the least significant input, and each later level by the next input up. The truth table and three mode bits are loaded serially before use. After loading they stay fixed until a new load replaces them.

A split bit chooses between two uses of the table. The first is one function of all K inputs. The second is two separate functions of the lower K-1 inputs, one held in each half of the table. The two halves are read by two identical sub-trees, and a last 2:1 stage on the top input joins them when the table is not split. Each of the two outputs has its own flip-flop after the table. A per-output select bit chooses whether that output shows the registered value or the combinational value.

Top module: `frac_lut_cell`

## Requirements
- R1: While `cfg_en` is high, one bit is shifted in per clock from `cfg_din`. Over K2 = 2**K + 3 clocks, the first bit lands in table index 2**K-1, and the following bits fill the indices downwards to 0. After the table come the split bit, then the register select for `out_main`, then the register select for `out_aux`. When `cfg_en` is low, the stored configuration does not change.
- R2: In unsplit mode (split bit 0), the combinational `out_main` equals table[A]. A is the address formed from `lut_in`, with `lut_in[0]` as its least significant bit.
- R3: In unsplit mode, the combinational `out_aux` equals table[A] with the top address bit forced to 0. This is the lower-half result.
- R4: In split mode (split bit 1), `out_main` equals table[{0, lut_in[K-2:0]}] and `out_aux` equals table[{1, lut_in[K-2:0]}]. `lut_in[K-1]` has no effect on either output.
- R5: With an output's register select at 0, that output follows the table lookup in the same cycle, with no clock edge in between.
- R6: With an output's register select at 1, that output shows the lookup value captured at the most recent rising edge at which `ce`=1, `rst`=0 and `cfg_en`=0. This gives one cycle of latency.
- R7: At an edge with `ce`=0, both output flip-flops keep their values.
- R8: `rst` is synchronous and active high. It clears both output flip-flops to 0 and takes priority over `ce`.
- R9: While `cfg_en` is high, both outputs read 0 and neither output flip-flop is updated.
- R10: A second configuration load fully replaces the function and the mode bits of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the output flip-flops |
| rst | input | 1 | Synchronous active-high clear of the output flip-flops |
| ce | input | 1 | Clock enable of the output flip-flops |
| cfg_en | input | 1 | Configuration shift enable; the outputs read 0 while it is high |
| cfg_din | input | 1 | Serial configuration data, table MSB first |
| lut_in | input | K (6) | Lookup address inputs |
| out_main | output | 1 | Full-table function, or lower-half function when split |
| out_aux | output | 1 | Lower-half function, or upper-half function when split |

## Verification
A wrong configuration bit shows up at once on the combinational outputs, but only when the inputs address that entry. The random address sweeps after each load are therefore meant to touch every entry within a few hundred cycles. A wrong mode bit changes every later sample: the half-table mirror is broken, the top input becomes ignored or relevant, or the register latency appears or disappears. A flip-flop that captures or holds at the wrong time shows one cycle after the faulty edge, on any output selected as registered.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;
  localparam int unsigned LUT_K = 6;

  // Mode bits in the order they follow the table on the serial chain.
  typedef struct packed {
    logic split;
    logic reg_main;
    logic reg_aux;
  } lut_mode_t;

  localparam int unsigned MODE_BITS = $bits(lut_mode_t);

  // Serial chain length for a table of k inputs.
  function automatic int unsigned chain_len(input int unsigned k);
    return (1 << k) + MODE_BITS;
  endfunction

  // Node offset of a given tree level in a flattened mux tree.
  function automatic int unsigned level_base(input int unsigned leaves,
                                             input int unsigned levels,
                                             input int unsigned lvl);
    return 2 * leaves - (2 << (levels - lvl));
  endfunction
endpackage

// File: rtl/frac_lut_cfg.sv
module frac_lut_cfg
  import frac_lut_pkg::*;
#(
  parameter int unsigned TABLE_BITS = 64
) (
  input  logic                  clk,
  input  logic                  cfg_en,
  input  logic                  cfg_din,
  output logic [TABLE_BITS-1:0] truth_bits,
  output lut_mode_t             mode
);
  localparam int unsigned CHAIN = TABLE_BITS + MODE_BITS;

  logic [CHAIN-1:0] chain_q;

  // MSB-first: the earliest bit travels to the top of the chain.
  always_ff @(posedge clk) begin
    if (cfg_en) chain_q <= {chain_q[CHAIN-2:0], cfg_din};
  end

  assign truth_bits = chain_q[CHAIN-1:MODE_BITS];
  assign mode       = chain_q[MODE_BITS-1:0];
endmodule

// File: rtl/frac_lut_tree.sv
module frac_lut_tree
  import frac_lut_pkg::*;
#(
  parameter int unsigned LEVELS = 5
) (
  input  logic [(1<<LEVELS)-1:0] leaf,
  input  logic [LEVELS-1:0]      sel,
  output logic                   root
);
  localparam int unsigned LEAVES = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  assign node[LEAVES-1:0] = leaf;

  // Level l halves the node count, steered by sel[l].
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int unsigned SRC = level_base(LEAVES, LEVELS, l);
    localparam int unsigned DST = level_base(LEAVES, LEVELS, l + 1);
    for (genvar k = 0; k < (LEAVES >> (l + 1)); k++) begin : g_mux
      assign node[DST+k] = sel[l] ? node[SRC+2*k+1] : node[SRC+2*k];
    end
  end

  assign root = node[NODES-1];
endmodule

// File: rtl/frac_lut_out.sv
module frac_lut_out (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic quiet,
  input  logic use_reg,
  input  logic comb_val,
  output logic q,
  output logic dout
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= comb_val;
  end

  always_comb begin
    if (quiet)        dout = 1'b0;
    else if (use_reg) dout = q;
    else              dout = comb_val;
  end
endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
  import frac_lut_pkg::*;
#(
  parameter int unsigned K = LUT_K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         cfg_en,
  input  logic         cfg_din,
  input  logic [K-1:0] lut_in,
  output logic         out_main,
  output logic         out_aux
);
  localparam int unsigned DEPTH = 1 << K;
  localparam int unsigned HALF  = DEPTH / 2;

  logic [DEPTH-1:0] truth_bits;
  lut_mode_t        mode;

  // Named internal events for the checker.
  logic       cfg_active;
  logic       ff_load;
  logic       half_lo;
  logic       half_hi;
  logic       full_val;
  logic [1:0] comb_v;
  logic [1:0] reg_sel;
  logic [1:0] q_v;
  logic [1:0] dout_v;

  frac_lut_cfg #(.TABLE_BITS(DEPTH)) u_cfg (
    .clk        (clk),
    .cfg_en     (cfg_en),
    .cfg_din    (cfg_din),
    .truth_bits (truth_bits),
    .mode       (mode)
  );

  // Two half trees on the low inputs; one joining stage on the top input.
  frac_lut_tree #(.LEVELS(K-1)) u_tree_lo (
    .leaf (truth_bits[HALF-1:0]),
    .sel  (lut_in[K-2:0]),
    .root (half_lo)
  );

  frac_lut_tree #(.LEVELS(K-1)) u_tree_hi (
    .leaf (truth_bits[DEPTH-1:HALF]),
    .sel  (lut_in[K-2:0]),
    .root (half_hi)
  );

  assign full_val   = lut_in[K-1] ? half_hi : half_lo;
  assign cfg_active = cfg_en;
  assign ff_load    = ce & ~rst & ~cfg_active;

  assign comb_v[0]  = mode.split ? half_lo : full_val;
  assign comb_v[1]  = mode.split ? half_hi : half_lo;
  assign reg_sel    = {mode.reg_aux, mode.reg_main};

  for (genvar o = 0; o < 2; o++) begin : g_out
    frac_lut_out u_out (
      .clk      (clk),
      .rst      (rst),
      .load     (ff_load),
      .quiet    (cfg_active),
      .use_reg  (reg_sel[o]),
      .comb_val (comb_v[o]),
      .q        (q_v[o]),
      .dout     (dout_v[o])
    );
  end

  assign out_main = dout_v[0];
  assign out_aux  = dout_v[1];
endmodule

// File: rtl/frac_lut_cell_chk.sv
module frac_lut_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_en,
  input logic       ff_load,
  input logic       split,
  input logic       top_in,
  input logic [1:0] comb_v,
  input logic [1:0] q_v,
  input logic [1:0] reg_sel,
  input logic       out_main,
  input logic       out_aux
);
  p_cfg_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (out_main == 1'b0 && out_aux == 1'b0));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (q_v == $past(q_v)));

  p_rst_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_v == 2'b00));

  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    ff_load |=> (q_v == $past(comb_v)));

  p_ce_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ff_load |=> (q_v == $past(q_v)));

  p_half_mirror_r3: assert property (@(posedge clk) disable iff (rst)
    (!split && !top_in) |-> (comb_v[0] == comb_v[1]));

  p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !reg_sel[0]) |-> (out_main == comb_v[0]));
endmodule

bind frac_lut_cell frac_lut_cell_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .ff_load  (ff_load),
  .split    (mode.split),
  .top_in   (lut_in[K-1]),
  .comb_v   (comb_v),
  .q_v      (q_v),
  .reg_sel  (reg_sel),
  .out_main (out_main),
  .out_aux  (out_aux)
);

// File: tb/frac_lut_cell_tb.sv
`timescale 1ns/1ps
module frac_lut_cell_tb;
  localparam int K = 6;
  localparam int DEPTH = 1 << K;

  logic clk = 1'b0;
  logic rst, ce, cfg_en, cfg_din;
  logic [K-1:0] lut_in;
  logic out_main, out_aux;

  int checks = 0;
  int errors = 0;
  int seed_dummy;

  // Bench model of the configuration and the two flip-flops.
  logic [DEPTH-1:0] m_tab;
  logic m_split, m_rm, m_ra;
  logic m_q0 = 1'b0, m_q1 = 1'b0;

  always #2.5 clk = ~clk;

  frac_lut_cell #(.K(K)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .lut_in(lut_in), .out_main(out_main), .out_aux(out_aux)
  );

  // Expected lookup: which=0 is out_main, which=1 is out_aux.
  function automatic logic model_lookup(input int which, input logic [K-1:0] a);
    int idx;
    int low = int'(a) % (DEPTH / 2);
    if (m_split) idx = (which == 1) ? low + DEPTH / 2 : low;
    else         idx = (which == 0) ? int'(a) : low;
    return m_tab[idx];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (in=%h split=%b)", tag, act, exp, lut_in, m_split);
    end
  endtask

  task automatic step(input logic [K-1:0] a, input logic c, input logic r,
                      input logic cen, input logic din, input string note);
    logic e0, e1;
    string t0, t1;
    @(negedge clk);
    lut_in = a; ce = c; rst = r; cfg_en = cen; cfg_din = din;
    @(posedge clk);
    if (r) begin
      m_q0 = 1'b0; m_q1 = 1'b0;
    end else if (c && !cen) begin
      m_q0 = model_lookup(0, a); m_q1 = model_lookup(1, a);
    end
    #1;
    if (cen) begin
      e0 = 1'b0; e1 = 1'b0; t0 = "R9"; t1 = "R9";
    end else begin
      e0 = m_rm ? m_q0 : model_lookup(0, a);
      e1 = m_ra ? m_q1 : model_lookup(1, a);
      t0 = m_rm ? "R6" : (m_split ? "R4 R5" : "R2 R5");
      t1 = m_ra ? "R6" : (m_split ? "R4 R5" : "R3 R5");
    end
    check({t0, " main ", note}, out_main, e0);
    check({t1, " aux ", note}, out_aux, e1);
  endtask

  task automatic load_cfg(input logic [DEPTH-1:0] tab, input logic s,
                          input logic rm, input logic ra, input logic r);
    for (int i = DEPTH - 1; i >= 0; i--)
      step(K'($urandom), 1'b1, r, 1'b1, tab[i], "R1 loading");
    step(K'($urandom), 1'b1, r, 1'b1, s,  "R1 loading");
    step(K'($urandom), 1'b1, r, 1'b1, rm, "R1 loading");
    step(K'($urandom), 1'b1, r, 1'b1, ra, "R1 loading");
    m_tab = tab; m_split = s; m_rm = rm; m_ra = ra;
  endtask

  task automatic random_run(input int n, input string note);
    for (int i = 0; i < n; i++)
      step(K'($urandom), ($urandom % 5) != 0, ($urandom % 32) == 0, 1'b0, 1'b0, note);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [DEPTH-1:0] tab;
    seed_dummy = $urandom(32'h5eed_1234);
    rst = 1'b1; ce = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; lut_in = '0;
    m_tab = '0; m_split = 1'b0; m_rm = 1'b1; m_ra = 1'b1;

    // Load under reset, then check the cleared registered outputs (R8).
    load_cfg({$urandom, $urandom}, 1'b0, 1'b1, 1'b1, 1'b1);
    step(6'h3f, 1'b1, 1'b1, 1'b0, 1'b0, "R8 reset state");
    check("R8 reset main", out_main, 1'b0);
    check("R8 reset aux", out_aux, 1'b0);
    random_run(200, "R1 R6 first config");

    // R7: clock enable low holds registers while inputs move.
    step(6'h15, 1'b1, 1'b0, 1'b0, 1'b0, "R7 capture");
    for (int i = 0; i < 6; i++)
      step(K'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, "R7 ce low");

    // R8: reset wins over clock enable.
    step(6'h2a, 1'b1, 1'b1, 1'b0, 1'b0, "R8 priority");

    // Every mode combination with a random table (R1, R10 reconfiguration).
    for (int m = 0; m < 8; m++) begin
      tab = {$urandom, $urandom};
      load_cfg(tab, m[2], m[1], m[0], 1'b0);
      random_run(150, "R1 R10 reconfig");
    end

    // Single-entry tables at both ends, unsplit combinational.
    load_cfg(64'h1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(6'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R1 R2 entry 0");
    step(6'h3f, 1'b1, 1'b0, 1'b0, 1'b0, "R2 entry 63 off");
    load_cfg(64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    step(6'h3f, 1'b1, 1'b0, 1'b0, 1'b0, "R1 R2 entry 63");
    step(6'h1f, 1'b1, 1'b0, 1'b0, 1'b0, "R3 entry 31 off");

    // R4: top input ignored in split mode.
    load_cfg({32'hA5A5_0F0F, 32'h3C3C_F00F}, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      step(K'(i), 1'b1, 1'b0, 1'b0, 1'b0, "R4 top low");
      step(K'(i + 32), 1'b1, 1'b0, 1'b0, 1'b0, "R4 top high");
    end

    // R9: registers keep their value across a full reload.
    load_cfg({$urandom, $urandom}, 1'b0, 1'b1, 1'b1, 1'b0);
    step(6'h07, 1'b1, 1'b0, 1'b0, 1'b0, "R6 capture before reload");
    load_cfg({$urandom, $urandom}, 1'b1, 1'b1, 1'b1, 1'b0);
    step(6'h07, 1'b0, 1'b0, 1'b0, 1'b0, "R9 held across reload");
    random_run(100, "R10 final");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule